// File: doc/BRIEF.md
# Delayed Load/Store Request Scheduler

This block holds the memory requests of in-flight loads and stores in two separate first-in first-out queues and releases them at a controlled rate. Each entry records the value of a free-running internal cycle counter when it is inserted. It becomes eligible only after a fixed extra latency, which models memory delay beyond the base cache access. Entries inserted in the same cycle share a stamp and so form one group.

Each cycle the scheduler compares the two queue heads and repeatedly takes the one that became ready earlier; when both became ready in the same cycle, the store is taken. It stops when a per-cycle load limit, store limit or total limit is reached, or when no head is eligible. Selected loads go out as read requests on parallel issue lanes. A store's write goes to memory in the same cycle it is inserted, so a selected store entry is simply dropped. It still takes up one of the cycle's request slots. This models contention between loads and stores. A downstream `rd_ready` low freezes both queues for that cycle.

Top module: `mem_req_sched`

## Requirements
- R1: After reset both queues are empty: `rd_valid` is all zero, `st_pop` is zero, and `ld_full` and `st_full` are low.
- R2: When `st_push` is high and `st_full` is low, `wr_valid` is high in that same cycle, with `wr_addr` equal to `st_addr` and `wr_data` equal to `st_data`. Otherwise `wr_valid` is low.
- R3: An entry inserted in the cycle when the internal counter reads `s` can be selected only once the counter, modulo 2^CW, has advanced at least LAT past `s`. This is LAT cycles after the insertion cycle, and the rule holds across counter wrap.
- R4: Loads leave the load queue in insertion order, and stores leave the store queue in insertion order.
- R5: Each selection slot takes whichever eligible head has the larger age (counter minus stamp). When the ages are equal, the store is taken.
- R6: In one cycle at most MAX_LD loads, at most MAX_ST stores and at most MAX_TOT entries in total are selected. Selection ends for the cycle as soon as any of these counts reaches its limit, or when no head is eligible.
- R7: Selected loads occupy issue lanes 0 upward in selection order, so `rd_valid` is a contiguous run of ones from bit 0. Lane k carries its load's address in `rd_addr[k*AW +: AW]` and its tag in `rd_tag[k*TW +: TW]`.
- R8: Selecting a store issues no read. `st_pop` reports the number of store entries removed in the cycle.
- R9: While `rd_ready` is low, no entry leaves either queue and `st_pop` is zero. `rd_valid` and the lane contents do not depend on `rd_ready`.
- R10: `ld_full` (`st_full`) is high when the load (store) queue holds DEPTH entries. A push in such a cycle is ignored: no entry is added, and for a store no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_push | input | 1 | Insert a load request |
| ld_addr | input | AW | Load address |
| ld_tag | input | TW | Load identifier |
| ld_full | output | 1 | Load queue full |
| st_push | input | 1 | Insert a store request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_full | output | 1 | Store queue full |
| wr_valid | output | 1 | Write issued this cycle |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| rd_valid | output | MAX_LD | Per-lane read-issue valid |
| rd_addr | output | MAX_LD*AW | Per-lane read address |
| rd_tag | output | MAX_LD*TW | Per-lane load identifier |
| rd_ready | input | 1 | Read issue accepted; allows removal this cycle |
| st_pop | output | $clog2(MAX_ST+1) | Store entries removed this cycle |

## Verification
The bench uses DEPTH=4, CW=4, LAT=3, MAX_LD=2, MAX_ST=2 and MAX_TOT=3. With a 4-bit counter, the stamp wraps every 16 cycles, so long runs test wrap-safe aging hundreds of times. With limits of 2, 2 and 3, each of the three limits is the binding one in different mixes, and a directed sequence makes tie priority visible through which lanes fire. Stall-heavy phases fill both 4-entry queues, so pushes against a full queue are tested often.

// File: rtl/mem_req_sched.sv
module mem_req_sched #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TW      = 6,
  parameter int DEPTH   = 8,
  parameter int CW      = 8,
  parameter int LAT     = 4,
  parameter int MAX_LD  = 2,
  parameter int MAX_ST  = 1,
  parameter int MAX_TOT = 2,
  localparam int SPW    = $clog2(MAX_ST + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_push,
  input  logic [AW-1:0]        ld_addr,
  input  logic [TW-1:0]        ld_tag,
  output logic                 ld_full,
  input  logic                 st_push,
  input  logic [AW-1:0]        st_addr,
  input  logic [DW-1:0]        st_data,
  output logic                 st_full,
  output logic                 wr_valid,
  output logic [AW-1:0]        wr_addr,
  output logic [DW-1:0]        wr_data,
  output logic [MAX_LD-1:0]    rd_valid,
  output logic [MAX_LD*AW-1:0] rd_addr,
  output logic [MAX_LD*TW-1:0] rd_tag,
  input  logic                 rd_ready,
  output logic [SPW-1:0]       st_pop
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int LNW  = $clog2(MAX_LD + 1);

  logic [CW-1:0]   now;
  logic [AW-1:0]   lq_addr  [DEPTH];
  logic [TW-1:0]   lq_tag   [DEPTH];
  logic [CW-1:0]   lq_stamp [DEPTH];
  logic [CW-1:0]   sq_stamp [DEPTH];
  logic [PW-1:0]   lq_rd, lq_wr, sq_rd, sq_wr;
  logic [CNTW-1:0] lq_cnt, sq_cnt;
  logic [LNW-1:0]  n_ld;
  logic [SPW-1:0]  n_st;
  logic            ld_in, st_in;

  assign ld_full  = lq_cnt == CNTW'(DEPTH);
  assign st_full  = sq_cnt == CNTW'(DEPTH);
  assign ld_in    = ld_push && !ld_full;
  assign st_in    = st_push && !st_full;
  assign wr_valid = st_in;
  assign wr_addr  = st_addr;
  assign wr_data  = st_data;
  assign st_pop   = rd_ready ? n_st : '0;

  always_comb begin
    logic          halt, l_ok, s_ok;
    logic [PW-1:0] li, si;
    logic [CW-1:0] l_age, s_age;
    n_ld     = '0;
    n_st     = '0;
    rd_valid = '0;
    rd_addr  = '0;
    rd_tag   = '0;
    halt     = 1'b0;
    for (int s = 0; s < MAX_TOT; s++) begin
      li    = lq_rd + PW'(n_ld);
      si    = sq_rd + PW'(n_st);
      l_age = now - lq_stamp[li];
      s_age = now - sq_stamp[si];
      l_ok  = !halt && (int'(lq_cnt) > int'(n_ld)) && (l_age >= CW'(LAT));
      s_ok  = !halt && (int'(sq_cnt) > int'(n_st)) && (s_age >= CW'(LAT));
      if (s_ok && (!l_ok || s_age >= l_age)) begin
        n_st = n_st + SPW'(1);
      end else if (l_ok) begin
        rd_valid[n_ld]           = 1'b1;
        rd_addr[n_ld*AW +: AW]   = lq_addr[li];
        rd_tag[n_ld*TW +: TW]    = lq_tag[li];
        n_ld = n_ld + LNW'(1);
      end else begin
        halt = 1'b1;
      end
      if (int'(n_ld) == MAX_LD || int'(n_st) == MAX_ST) halt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now    <= '0;
      lq_rd  <= '0;
      lq_wr  <= '0;
      sq_rd  <= '0;
      sq_wr  <= '0;
      lq_cnt <= '0;
      sq_cnt <= '0;
    end else begin
      now <= now + CW'(1);
      if (ld_in) lq_wr <= lq_wr + PW'(1);
      if (st_in) sq_wr <= sq_wr + PW'(1);
      if (rd_ready) begin
        lq_rd <= lq_rd + PW'(n_ld);
        sq_rd <= sq_rd + PW'(n_st);
      end
      lq_cnt <= lq_cnt + CNTW'(ld_in) - (rd_ready ? CNTW'(n_ld) : CNTW'(0));
      sq_cnt <= sq_cnt + CNTW'(st_in) - (rd_ready ? CNTW'(n_st) : CNTW'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (ld_in) begin
      lq_addr[lq_wr]  <= ld_addr;
      lq_tag[lq_wr]   <= ld_tag;
      lq_stamp[lq_wr] <= now;
    end
    if (st_in) sq_stamp[sq_wr] <= now;
  end

  // R2
  write_at_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (st_push && !st_full));
  // R3
  fresh_not_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 1 && lq_cnt == '0 && ld_push) |=> rd_valid == '0);
  // R6
  slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rd_valid) + int'(n_st)) <= MAX_TOT);
  // R7
  lane_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid[0] |-> rd_valid == '0);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && !ld_push && !st_push) |=>
      (lq_cnt == $past(lq_cnt) && sq_cnt == $past(sq_cnt)));
  // R10
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_full && !rd_ready) |=> lq_cnt == $past(lq_cnt));
  // R8
  store_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && st_pop != '0 && !st_push) |=>
      sq_cnt == $past(sq_cnt) - CNTW'($past(st_pop)));
endmodule

// File: tb/sim_mem_req_sched.sv
`timescale 1ns/1ps
module sim_mem_req_sched;
  localparam int LAT = 3, DEPTH = 4;
  logic clk = 0, rst_n = 0;
  logic ld_push = 0, st_push = 0, rd_ready = 1;
  logic [7:0] ld_addr = 0, st_addr = 0, st_data = 0, wr_addr, wr_data;
  logic [3:0] ld_tag = 0;
  logic ld_full, st_full, wr_valid;
  logic [1:0] rd_valid, st_pop;
  logic [15:0] rd_addr;
  logic [7:0] rd_tag;
  int total = 0, bad = 0, cyc = 0, seq = 0;
  int lq_pc[$], lq_a[$], lq_t[$], sq_pc[$];

  always #2.5 clk = ~clk;

  mem_req_sched #(.AW(8), .DW(8), .TW(4), .DEPTH(DEPTH), .CW(4), .LAT(LAT),
                  .MAX_LD(2), .MAX_ST(2), .MAX_TOT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_push(ld_push), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .ld_full(ld_full), .st_push(st_push), .st_addr(st_addr), .st_data(st_data),
    .st_full(st_full), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_ready(rd_ready),
    .st_pop(st_pop));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic step(bit lp, bit sp, bit rdy);
    int nl = 0, ns = 0;
    bit halt = 0, lok, sok, lpush, spush;
    logic [1:0] ev = '0;
    logic [15:0] ea = '0;
    logic [7:0] et = '0;
    if ((lq_pc.size() > 0 && cyc - lq_pc[0] >= 9) || (sq_pc.size() > 0 && cyc - sq_pc[0] >= 9))
      rdy = 1;
    seq++;
    ld_push = lp; ld_addr = 8'(seq * 7); ld_tag = 4'(seq);
    st_push = sp; st_addr = 8'(seq * 13 + 1); st_data = 8'(seq * 5 + 3);
    rd_ready = rdy;
    #1;
    for (int s = 0; s < 3; s++) begin
      lok = !halt && lq_pc.size() > nl && (cyc - lq_pc[nl]) >= LAT;
      sok = !halt && sq_pc.size() > ns && (cyc - sq_pc[ns]) >= LAT;
      if (sok && (!lok || (cyc - sq_pc[ns]) >= (cyc - lq_pc[nl]))) ns++;
      else if (lok) begin
        ev[nl] = 1; ea[nl*8 +: 8] = 8'(lq_a[nl]); et[nl*4 +: 4] = 4'(lq_t[nl]); nl++;
      end else halt = 1;
      if (nl == 2 || ns == 2) halt = 1;
    end
    lpush = lp && lq_pc.size() < DEPTH;
    spush = sp && sq_pc.size() < DEPTH;
    chk("R3/R5/R6/R7 rd_valid", rd_valid, ev);
    chk("R4/R7 rd_addr", rd_addr & {{8{ev[1]}}, {8{ev[0]}}}, ea);
    chk("R4/R7 rd_tag", rd_tag & {{4{ev[1]}}, {4{ev[0]}}}, et);
    chk("R8/R9 st_pop", st_pop, rdy ? ns : 0);
    chk("R10 full flags", {ld_full, st_full}, {lq_pc.size() == DEPTH, sq_pc.size() == DEPTH});
    chk("R2/R10 wr_valid", wr_valid, spush);
    if (spush) chk("R2 wr_addr/data", {wr_addr, wr_data}, {st_addr, st_data});
    @(posedge clk);
    if (rdy) begin
      repeat (nl) begin void'(lq_pc.pop_front()); void'(lq_a.pop_front()); void'(lq_t.pop_front()); end
      repeat (ns) void'(sq_pc.pop_front());
    end
    if (lpush) begin lq_pc.push_back(cyc); lq_a.push_back(int'(ld_addr)); lq_t.push_back(int'(ld_tag)); end
    if (spush) sq_pc.push_back(cyc);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #750000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 st_pop", st_pop, 0);
    chk("R1 full", {ld_full, st_full}, 0);
    rst_n = 1;
    // R3: single load becomes selectable exactly LAT cycles after insertion
    step(1, 0, 1); chk("R3 age1", rd_valid, 0);
    step(0, 0, 1); chk("R3 age2", rd_valid, 0);
    step(0, 0, 1); chk("R3 age3", rd_valid, 2'b01);
    // R9: stall keeps the entry
    step(0, 0, 0); chk("R9 held", rd_valid, 2'b01);
    step(0, 0, 1); chk("R4 drained", rd_valid, 0);
    // R5: two tied groups, total limit makes store priority visible
    step(1, 1, 0); step(1, 1, 0); step(0, 0, 0); step(0, 0, 0);
    chk("R5 tie lanes", rd_valid, 2'b01);
    rd_ready = 1; #1;
    chk("R5 tie stores", st_pop, 2);
    step(0, 0, 1);
    chk("R4 remaining load", rd_valid, 2'b01);
    step(0, 0, 1);
    for (int p = 0; p < 5; p++)
      for (int i = 0; i < 900; i++) begin
        case (p)
          0: step($urandom_range(1) == 1, 0, 1);
          1: step(0, $urandom_range(1) == 1, $urandom_range(7) != 0);
          2: step(1, 1, 1);
          3: step($urandom_range(1) == 1, $urandom_range(1) == 1, $urandom_range(1) == 1);
          default: step($urandom_range(3) != 0, $urandom_range(3) != 0, $urandom_range(3) == 0);
        endcase
      end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule